// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects 32 level-sensitive interrupt sources and presents them to a processor on two outputs: a fast interrupt line and a normal interrupt line. Each source carries a software-pending bit that is ORed with its input pin. A per-source select bit steers it to the fast line. The fast line has no enable gating. Normal-line sources are gated by an enable register, which software sets and clears with write-one strobes.

Sixteen vector slots give chosen normal-line sources a fixed priority and a handler address. The slot index is the priority, and slot 0 is the highest. A handler starts when software reads the vector-address register. That read returns the handler address, raises the active priority level and saves the old level in a per-level slot. A handler ends when software writes the vector-address register, which pops back to the saved level. While a handler runs, only sources in higher-priority slots can drive the normal line. Sources without a slot drive it only when no handler is active.

Software reaches the block through a simple register port with read and write strobes. Read data is combinational in the strobe cycle. Both interrupt outputs are registered.

Top module: `vic_ctrl`

## Requirements
- R1: The raw vector is `src_i | soft`. It reads at offset 0x008. A write-1 to 0x018 sets soft bits, a write-1 to 0x01C clears them, and 0x018 reads back the soft bits.
- R2: A write-1 to 0x010 sets enable bits and a write-1 to 0x014 clears them; 0x010 reads back the enables. Offset 0x000 reads `raw & enable & ~select`. Writes to 0x000 change no state.
- R3: Offset 0x00C is the read/write select register, and 0x004 reads `raw & select`. `fiq_o` is high in the clock after any bit of `raw & select` is set, and low in the clock after none is.
- R4: The active level runs from 0 to 17, and 17 means idle. `irq_o` is registered from the OR of `status & mask[level]`. The mask for level 17 is all ones, so when idle any enabled, unselected raw source raises `irq_o`.
- R5: The vector control byte for slot k sits at 0x200+4k and the handler address at 0x100+4k. Control bit 5 enables the slot and bits 4:0 name its source. `mask[i]` is the OR of the sources of the enabled slots below i.
- R6: A read of 0x030 finds the smallest i below the active level with `raw & mask[i+1]` nonzero. It saves the active level in slot i, makes i the active level, and returns address i. Index 16 is the default address at 0x034.
- R7: A write to 0x030 ignores its data. When the active level is below 17, the level becomes the value saved for it.
- R8: A read of 0x030 with no match returns the default address when idle, and the address of the active level otherwise. The level is left unchanged.
- R9: Offset 0x020 stores and returns bit 0 of the written data as the protection bit.
- R10: Offsets 0xFE0 to 0xFFC return 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. Undecoded offsets read 0.
- R11: Reset clears all registers and both outputs, and sets the active level to 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt inputs |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. That is what decides whether a vector-address access pushes or pops the level, so one of the properties checks for it. The bench drives exactly one strobe per access task, each held for one cycle, so the rule is never broken. The bench also changes `src_i` only on falling edges and waits two cycles before reading the registered outputs. This keeps the level-push properties unambiguous about which raw value they see.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC   = 32;
    localparam int NSLOT  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int LVL_W  = $clog2(NSLOT + 2);
    localparam int IDLE   = NSLOT + 1;
    localparam int DEF_IX = NSLOT;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic [1:0]       spare;
        logic             on;
        logic [SRC_W-1:0] src;
    } vctl_t;

    localparam logic [ADDR_W-1:0] OFS_IRQST = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_FIQST = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SEL   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_SWSET = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_SWCLR = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_PROT  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_VEC   = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_DEF   = 12'h034;

    function automatic logic [7:0] ident_byte(input logic [2:0] ix);
        case (ix)
            3'd0: ident_byte = 8'h90;
            3'd1: ident_byte = 8'h11;
            3'd2: ident_byte = 8'h04;
            3'd3: ident_byte = 8'h00;
            3'd4: ident_byte = 8'h0D;
            3'd5: ident_byte = 8'hF0;
            3'd6: ident_byte = 8'h05;
            default: ident_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/vic_mask_gen.sv
module vic_mask_gen
    import vic_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_SLOT = NSLOT
) (
    input  vctl_t [N_SLOT-1:0]             ctl,
    output logic  [N_SLOT+1:0][N_SRC-1:0]  mask
);
    assign mask[0]        = '0;
    assign mask[N_SLOT+1] = '1;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_lvl
        logic [N_SRC-1:0] own;
        assign own         = ctl[g].on ? (N_SRC'(1) << ctl[g].src) : '0;
        assign mask[g + 1] = mask[g] | own;
    end
endmodule

// File: rtl/vic_nest.sv
module vic_nest
    import vic_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_SLOT = NSLOT
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ack,
    input  logic                            done,
    input  logic [N_SRC-1:0]                raw,
    input  logic [N_SLOT+1:0][N_SRC-1:0]    mask,
    output lvl_t                            cur_lvl,
    output logic                            hit,
    output lvl_t                            hit_lvl
);
    localparam lvl_t IDLE_L = lvl_t'(N_SLOT + 1);

    lvl_t [N_SLOT:0] saved;

    always_comb begin
        hit     = 1'b0;
        hit_lvl = '0;
        for (int i = N_SLOT; i >= 0; i--) begin
            if (lvl_t'(i) < cur_lvl && |(raw & mask[i + 1])) begin
                hit     = 1'b1;
                hit_lvl = lvl_t'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl <= IDLE_L;
            for (int k = 0; k <= N_SLOT; k++) saved[k] <= IDLE_L;
        end else if (done) begin
            if (cur_lvl != IDLE_L) cur_lvl <= saved[cur_lvl];
        end else if (ack && hit) begin
            saved[hit_lvl] <= cur_lvl;
            cur_lvl        <= hit_lvl;
        end
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam lvl_t IDLE_L = lvl_t'(IDLE);

    logic [NSRC-1:0]             soft_q, en_q, sel_q;
    logic                        prot_q;
    vctl_t [NSLOT-1:0]           ctl_q;
    logic [NSLOT:0][DATA_W-1:0]  vaddr_q;

    logic [NSRC-1:0]             raw_lvl, irq_stat;
    logic [NSLOT+1:0][NSRC-1:0]  mask;
    lvl_t                        cur_lvl, hit_lvl, vec_ix;
    logic                        hit, vec_rd, vec_wr;
    logic                        in_vaddr, in_vctl, in_ident;

    assign raw_lvl  = src_i | soft_q;
    assign irq_stat = raw_lvl & en_q & ~sel_q;
    assign in_vaddr = addr[11:6] == 6'b000100;
    assign in_vctl  = addr[11:6] == 6'b001000;
    assign in_ident = addr[11:5] == 7'h7F;
    assign vec_rd   = rd_en && addr == OFS_VEC;
    assign vec_wr   = wr_en && addr == OFS_VEC;

    vic_mask_gen #(.N_SRC(NSRC), .N_SLOT(NSLOT)) mask_i (
        .ctl  (ctl_q),
        .mask (mask)
    );

    vic_nest #(.N_SRC(NSRC), .N_SLOT(NSLOT)) nest_i (
        .clk     (clk),
        .rst     (rst),
        .ack     (vec_rd),
        .done    (vec_wr),
        .raw     (raw_lvl),
        .mask    (mask),
        .cur_lvl (cur_lvl),
        .hit     (hit),
        .hit_lvl (hit_lvl)
    );

    // Address returned by a vector read: matched level, else active level
    // (idle maps to the default entry).
    assign vec_ix = hit ? hit_lvl : (cur_lvl == IDLE_L ? lvl_t'(DEF_IX) : cur_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q  <= '0;
            en_q    <= '0;
            sel_q   <= '0;
            prot_q  <= 1'b0;
            ctl_q   <= '0;
            vaddr_q <= '0;
        end else if (wr_en) begin
            if (in_vaddr) vaddr_q[addr[5:2]] <= wdata;
            if (in_vctl)  ctl_q[addr[5:2]]   <= vctl_t'(wdata[7:0]);
            case (addr)
                OFS_SEL:   sel_q  <= wdata;
                OFS_ENSET: en_q   <= en_q | wdata;
                OFS_ENCLR: en_q   <= en_q & ~wdata;
                OFS_SWSET: soft_q <= soft_q | wdata;
                OFS_SWCLR: soft_q <= soft_q & ~wdata;
                OFS_PROT:  prot_q <= wdata[0];
                OFS_DEF:   vaddr_q[DEF_IX] <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(irq_stat & mask[cur_lvl]);
            fiq_o <= |(raw_lvl & sel_q);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (in_vaddr)      rdata = vaddr_q[addr[5:2]];
            else if (in_vctl)  rdata = {{(DATA_W-8){1'b0}}, ctl_q[addr[5:2]]};
            else if (in_ident) rdata = {{(DATA_W-8){1'b0}}, ident_byte(addr[4:2])};
            else begin
                case (addr)
                    OFS_IRQST: rdata = irq_stat;
                    OFS_FIQST: rdata = raw_lvl & sel_q;
                    OFS_RAW:   rdata = raw_lvl;
                    OFS_SEL:   rdata = sel_q;
                    OFS_ENSET: rdata = en_q;
                    OFS_SWSET: rdata = soft_q;
                    OFS_PROT:  rdata = {{(DATA_W-1){1'b0}}, prot_q};
                    OFS_VEC:   rdata = vaddr_q[vec_ix];
                    OFS_DEF:   rdata = vaddr_q[DEF_IX];
                    default:   rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [NSRC-1:0]   raw_lvl,
    input logic [NSRC-1:0]   sel_q,
    input logic [NSRC-1:0]   irq_stat,
    input lvl_t              cur_lvl
);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    // R4
    lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur_lvl <= lvl_t'(IDLE));

    // R4
    idle_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_lvl == lvl_t'(IDLE) && |irq_stat) |=> irq_o);

    // R3
    fiq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        |(raw_lvl & sel_q) |=> fiq_o);

    // R3
    fiq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(raw_lvl & sel_q)) |=> !fiq_o);

    // R6
    vec_push_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_VEC && cur_lvl == lvl_t'(IDLE) && |raw_lvl)
        |=> cur_lvl < lvl_t'(IDLE));

    // R7
    idle_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_VEC && cur_lvl == lvl_t'(IDLE))
        |=> cur_lvl == lvl_t'(IDLE));

    // R10
    undecoded_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 12'h02C) |-> rdata == '0);
endmodule

bind vic_ctrl vic_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .raw_lvl  (raw_lvl),
    .sel_q    (sel_q),
    .irq_stat (irq_stat),
    .cur_lvl  (cur_lvl)
);

// File: tb/vic_ctrl_tb_top.sv
module vic_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    vic_ctrl dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R11 irq_o", {31'b0, irq_o}, 32'h0);
        check("R11 fiq_o", {31'b0, fiq_o}, 32'h0);
        rd(12'h010, d); check("R11 enable", d, 32'h0);
        rd(12'h00C, d); check("R11 select", d, 32'h0);
        rd(12'h034, d); check("R11 default addr", d, 32'h0);
        rd(12'h104, d); check("R11 vector addr", d, 32'h0);
        rd(12'h208, d); check("R11 vector ctl", d, 32'h0);
    endtask

    task automatic t_raw_soft();
        logic [31:0] d;
        src_i = 32'h5;
        wr(12'h018, 32'h30);
        rd(12'h008, d); check("R1 raw after soft set", d, 32'h35);
        wr(12'h01C, 32'h10);
        rd(12'h008, d); check("R1 raw after soft clear", d, 32'h25);
        rd(12'h018, d); check("R1 soft readback", d, 32'h20);
    endtask

    task automatic t_enable_status();
        logic [31:0] d;
        wr(12'h010, 32'h0F);
        wr(12'h014, 32'h02);
        rd(12'h010, d); check("R2 enable set/clear", d, 32'h0D);
        wr(12'h00C, 32'h04);
        rd(12'h000, d); check("R2 irq status", d, 32'h01);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h010, d); check("R2 enable after status write", d, 32'h0D);
        rd(12'h000, d); check("R2 status after status write", d, 32'h01);
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        rd(12'h004, d); check("R3 fiq status", d, 32'h04);
        settle();
        check("R3 fiq_o high", {31'b0, fiq_o}, 32'h1);
        wr(12'h00C, 32'h0);
        rd(12'h00C, d); check("R3 select readback", d, 32'h0);
        settle();
        check("R3 fiq_o low", {31'b0, fiq_o}, 32'h0);
        src_i = '0;
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h014, 32'hFFFF_FFFF);
    endtask

    task automatic t_idle_irq();
        wr(12'h010, 32'h8);
        src_i = 32'h8;
        settle();
        check("R4 irq idle high", {31'b0, irq_o}, 32'h1);
        src_i = 32'h0;
        settle();
        check("R4 irq idle low", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_nesting();
        logic [31:0] d;
        wr(12'h200, 32'h27);      // slot 0 -> source 7
        wr(12'h100, 32'hA000);
        wr(12'h204, 32'h23);      // slot 1 -> source 3
        wr(12'h104, 32'hB000);
        wr(12'h034, 32'hD000);
        wr(12'h010, 32'h288);     // sources 3, 7, 9
        rd(12'h204, d); check("R5 ctl readback", d, 32'h23);
        rd(12'h104, d); check("R5 addr readback", d, 32'hB000);
        src_i = 32'h8;
        settle();
        check("R4 irq before ack", {31'b0, irq_o}, 32'h1);
        rd(12'h030, d); check("R6 ack slot1", d, 32'hB000);
        settle();
        check("R5 same level masked", {31'b0, irq_o}, 32'h0);
        src_i = 32'h208;
        settle();
        check("R5 unvectored masked", {31'b0, irq_o}, 32'h0);
        src_i = 32'h288;
        settle();
        check("R5 higher slot passes", {31'b0, irq_o}, 32'h1);
        rd(12'h030, d); check("R6 ack slot0", d, 32'hA000);
        settle();
        check("R6 level 0 masks all", {31'b0, irq_o}, 32'h0);
        wr(12'h030, 32'h1234);
        settle();
        check("R7 pop to level 1", {31'b0, irq_o}, 32'h1);
        src_i = 32'h208;
        wr(12'h030, 32'h0);
        settle();
        check("R7 pop to idle", {31'b0, irq_o}, 32'h1);
        src_i = 32'h200;
        rd(12'h030, d); check("R6 unvectored -> default", d, 32'hD000);
        settle();
        check("R6 level 16 masks unvectored", {31'b0, irq_o}, 32'h0);
        wr(12'h030, 32'h0);
        settle();
        check("R7 pop from 16", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_no_pending();
        logic [31:0] d;
        src_i = 32'h0;
        rd(12'h030, d); check("R8 idle no match", d, 32'hD000);
        src_i = 32'h200;
        settle();
        check("R8 level unchanged", {31'b0, irq_o}, 32'h1);
        src_i = 32'h0;
    endtask

    task automatic t_prot();
        logic [31:0] d;
        wr(12'h020, 32'hFF);
        rd(12'h020, d); check("R9 protection", d, 32'h1);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        logic [7:0] exp_id [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(k * 4), d);
            check("R10 ident byte", d, {24'b0, exp_id[k]});
        end
        rd(12'h02C, d); check("R10 undecoded 0x02C", d, 32'h0);
        rd(12'h028, d); check("R10 undecoded 0x028", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raw_soft();
        t_enable_status();
        t_fiq();
        t_idle_irq();
        t_nesting();
        t_no_pending();
        t_prot();
        t_ident();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule